// File: doc/BRIEF.md
# Immediate-Controlled Vector Permute Unit

This block rearranges the elements of a 128-bit vector under the control of an 8-bit immediate. It is one pipeline stage of a vector execution path. The instruction decoder hands it three things: the operand `src_j`, the value the destination register held before the operation (`src_d`), and the immediate. It also gives an operation code and an element size code. One clock later the block returns the complete new destination value, which the register file writes back.

There are three operation classes.

- **Group shuffle.** For 8, 16 and 32-bit elements, the vector is split into groups of four elements. Each output element picks one element of its own group in `src_j` using a 2-bit immediate field. For 64-bit elements, each of the two output doublewords picks its source (`src_j` or `src_d`) and its index from immediate bits.
- **Word permute.** The two low output words come from `src_j`. The two high output words come from `src_d`. Each is indexed by its own 2-bit immediate field.
- **Extract-insert.** One element of `src_j` is copied into one slot of the old destination. Every other slot of the destination keeps its old value.

All results are built from the operand values as presented, so no form sees a partially written destination.

Top module: `vec_imm_permute`

## Requirements
- R1: With `op_sel`=0 (group shuffle) and `esize` 0, 1 or 2 (8, 16 or 32-bit elements), output element i equals `src_j` element number (i with its two low bits cleared) + imm[2*(i mod 4)+1 : 2*(i mod 4)].
- R2: With `op_sel`=0 and `esize`=3 (64-bit elements), output doubleword 0 is taken from `src_j` when imm[1]=1 and from `src_d` when imm[1]=0, at doubleword index imm[0]. Output doubleword 1 is selected the same way by imm[3] (source) and imm[2] (index).
- R3: With `op_sel`=1 (word permute), output word 0 = `src_j` word imm[1:0] and output word 1 = `src_j` word imm[3:2]. Output word 2 = `src_d` word imm[5:4] and output word 3 = `src_d` word imm[7:6]. The `esize` value has no effect on the result.
- R4: With `op_sel`=2 (extract-insert), destination element (imm[7:4] & M) receives `src_j` element (imm[3:0] & M). M is 0xF, 0x7, 0x3 or 0x1 for `esize` 0, 1, 2 or 3.
- R5: With `op_sel`=2, every destination element other than the one written under R4 equals the same element of `src_d`.
- R6: With `op_sel`=3 (unassigned code), the result equals `src_d` unchanged.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` carries the value for that input in the same cycle.
- R8: After a cycle with `in_valid` low, `result` keeps its previous value.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `result` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operands and controls are valid this cycle |
| op_sel | input | 2 | 0 group shuffle, 1 word permute, 2 extract-insert, 3 pass old destination |
| esize | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| imm | input | 8 | Immediate control field |
| src_j | input | 128 | Source vector operand |
| src_d | input | 128 | Previous destination register value |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| result | output | 128 | New destination value |

## Verification
Every one of the 256 immediates is driven for each operation and size code, with fresh random operands, so every index field and every source-select bit is reached.

The checks are aimed at specific faults:

- **Wrong group base.** Clearing the wrong bits for the group base in the byte shuffle makes upper groups read from group 0.
- **Swapped source select.** Swapping the source-select sense in the doubleword shuffle returns `src_d` data where `src_j` was asked for.
- **Wrong insert mask.** A wrong mask in extract-insert either writes a slot outside the element count or aliases the slot index. Because the untouched elements are checked separately from the inserted one, a design that zeroes or clobbers neighbours is also reported.
- **Idle-cycle faults.** An idle cycle after each operation checks that `result` does not drift and that `out_valid` drops.

// File: rtl/vp_pkg.sv
// Package: shared encodings for the immediate-controlled permute unit.
// Assumes: the operation and size codes below are fixed by the decoder.
package vp_pkg;

    typedef enum logic [1:0] {
        VP_OP_GSHUF  = 2'd0,
        VP_OP_WPERM  = 2'd1,
        VP_OP_EXTINS = 2'd2,
        VP_OP_PASS   = 2'd3
    } vp_op_e;

    // Element size codes: element width = 8 << code
    localparam int VP_NUM_SIZES = 4;
    localparam int VP_MIN_EW    = 8;

endpackage

// File: rtl/vp_group_shuf.sv
// Module: group shuffle for one element width.
// For EW below 64, each output element picks an element of its own group of
// four in src_j through a 2-bit immediate field. For EW of 64, each output
// doubleword picks its source operand and index from immediate bits.
// Assumes: DATA_W is a multiple of 4*EW (EW < 64) or of 2*EW (EW == 64).
module vp_group_shuf #(
    parameter int DATA_W = 128,
    parameter int EW     = 8
) (
    input  logic [DATA_W-1:0] src_j,
    input  logic [DATA_W-1:0] src_d,
    input  logic [7:0]        imm,
    output logic [DATA_W-1:0] res
);
    localparam int NE = DATA_W / EW;

    generate
        if (EW == 64) begin : g_dword
            for (genvar i = 0; i < NE; i++) begin : g_el
                localparam int SLOT = i % 2;
                localparam int BASE = (i / 2) * 2;
                logic [DATA_W-1:0] pick_src;
                // choose operand by the slot's source bit
                assign pick_src = imm[2*SLOT+1] ? src_j : src_d;
                assign res[i*EW +: EW] =
                    pick_src[(BASE + int'(imm[2*SLOT])) * EW +: EW];
            end
        end else begin : g_quad
            for (genvar i = 0; i < NE; i++) begin : g_el
                localparam int SLOT = i % 4;
                localparam int BASE = (i / 4) * 4;
                // index inside the group of four taken from the slot's field
                assign res[i*EW +: EW] =
                    src_j[(BASE + int'(imm[2*SLOT +: 2])) * EW +: EW];
            end
        end
    endgenerate

endmodule

// File: rtl/vp_word_perm.sv
// Module: word permute. In every 128-bit lane the two low words come from
// src_j and the two high words come from src_d, each picked by its own
// 2-bit immediate field.
// Assumes: DATA_W is a multiple of 128.
module vp_word_perm #(
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] src_j,
    input  logic [DATA_W-1:0] src_d,
    input  logic [7:0]        imm,
    output logic [DATA_W-1:0] res
);
    localparam int LANE_W = 128;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int WW     = 32;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            for (genvar k = 0; k < 4; k++) begin : g_word
                logic [LANE_W-1:0] lane_src;
                // low words read src_j, high words read the old destination
                assign lane_src = (k < 2) ? src_j[l*LANE_W +: LANE_W]
                                          : src_d[l*LANE_W +: LANE_W];
                assign res[l*LANE_W + k*WW +: WW] =
                    lane_src[int'(imm[2*k +: 2]) * WW +: WW];
            end
        end
    endgenerate

endmodule

// File: rtl/vp_ext_ins.sv
// Module: extract-insert for one element width. Copies one src_j element into
// one slot of the old destination and keeps all other slots.
// Assumes: DATA_W / EW is a power of two no larger than 16, so both indices
// fit in the 4-bit immediate nibbles.
module vp_ext_ins #(
    parameter int DATA_W = 128,
    parameter int EW     = 8
) (
    input  logic [DATA_W-1:0] src_j,
    input  logic [DATA_W-1:0] src_d,
    input  logic [7:0]        imm,
    output logic [DATA_W-1:0] res
);
    localparam int NE = DATA_W / EW;
    localparam int IW = (NE > 1) ? $clog2(NE) : 1;

    logic [IW-1:0] src_idx;
    logic [IW-1:0] dst_idx;

    assign src_idx = imm[IW-1:0];
    assign dst_idx = imm[4 +: IW];

    // start from the old destination, then overwrite the single target slot
    always_comb begin
        res = src_d;
        res[int'(dst_idx) * EW +: EW] = src_j[int'(src_idx) * EW +: EW];
    end

endmodule

// File: rtl/vec_imm_permute.sv
// Module: top of the immediate-controlled permute unit. Builds every size
// variant of each operation in parallel, selects one by op_sel and esize,
// and registers the result with a one-cycle valid.
// Assumes: DATA_W is 128 for the lane-specific checks below; op code 3
// returns the old destination unchanged.
module vec_imm_permute
    import vp_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        esize,
    input  logic [7:0]        imm,
    input  logic [DATA_W-1:0] src_j,
    input  logic [DATA_W-1:0] src_d,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] gshuf_res  [VP_NUM_SIZES];
    logic [DATA_W-1:0] extins_res [VP_NUM_SIZES];
    logic [DATA_W-1:0] wperm_res;
    logic [DATA_W-1:0] next_res;
    vp_op_e            op;

    assign op = vp_op_e'(op_sel);

    generate
        for (genvar s = 0; s < VP_NUM_SIZES; s++) begin : g_size
            localparam int EW = VP_MIN_EW << s;

            vp_group_shuf #(.DATA_W(DATA_W), .EW(EW)) u_gshuf (
                .src_j (src_j),
                .src_d (src_d),
                .imm   (imm),
                .res   (gshuf_res[s])
            );

            vp_ext_ins #(.DATA_W(DATA_W), .EW(EW)) u_extins (
                .src_j (src_j),
                .src_d (src_d),
                .imm   (imm),
                .res   (extins_res[s])
            );
        end
    endgenerate

    vp_word_perm #(.DATA_W(DATA_W)) u_wperm (
        .src_j (src_j),
        .src_d (src_d),
        .imm   (imm),
        .res   (wperm_res)
    );

    // pick the result of the requested operation and element size
    always_comb begin
        case (op)
            VP_OP_GSHUF:  next_res = gshuf_res[esize];
            VP_OP_WPERM:  next_res = wperm_res;
            VP_OP_EXTINS: next_res = extins_res[esize];
            default:      next_res = src_d;
        endcase
    end

    // output register: load on a valid input, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    // R7: valid appears exactly one clock after the input strobe
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R8: an idle cycle leaves the result unchanged
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(result));

    // R3: word 2 of a word permute comes from the old destination
    assert_wperm_word2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_sel) == 2'd1) |->
        (result[95:64] == 32'($past(src_d) >> {$past(imm[5:4]), 5'b0})));

    // R2: doubleword 0 reads src_j when imm[1] is set
    assert_dword_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_sel) == 2'd0 &&
         $past(esize) == 2'd3 && $past(imm[1])) |->
        (result[63:0] == 64'($past(src_j) >> {$past(imm[0]), 6'b0})));

    // R5: inserting a doubleword at slot 0 keeps the upper doubleword
    assert_extins_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_sel) == 2'd2 &&
         $past(esize) == 2'd3 && !$past(imm[4])) |->
        (result[127:64] == $past(src_d[127:64])));

    // R6: the unassigned op code passes the old destination through
    assert_pass_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(op_sel) == 2'd3) |->
        (result == $past(src_d)));

endmodule

// File: tb/vec_imm_permute_tb.sv
// Bench: sweeps every immediate for every op and size code against a
// behavioural reference model, with an idle cycle after each operation.
module vec_imm_permute_tb_top;

    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    op_sel;
    logic [1:0]    esize;
    logic [7:0]    imm;
    logic [DW-1:0] src_j;
    logic [DW-1:0] src_d;
    logic          out_valid;
    logic [DW-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vec_imm_permute #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .esize     (esize),
        .imm       (imm),
        .src_j     (src_j),
        .src_d     (src_d),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [DW-1:0] get_el(logic [DW-1:0] v, int idx, int ew);
        logic [DW-1:0] r = '0;
        for (int b = 0; b < ew; b++) r[b] = v[idx*ew + b];
        return r;
    endfunction

    function automatic logic [DW-1:0] put_el(logic [DW-1:0] v, int idx, int ew,
                                             logic [DW-1:0] e);
        for (int b = 0; b < ew; b++) v[idx*ew + b] = e[b];
        return v;
    endfunction

    // reference model written from the requirements
    function automatic logic [DW-1:0] model(int op, int sz, int im,
                                            logic [DW-1:0] j, logic [DW-1:0] d);
        int ew = 8 << sz;
        int ne = DW / ew;
        logic [DW-1:0] r = d;
        if (op == 0 && sz < 3) begin
            for (int i = 0; i < ne; i++) begin
                int k = (i / 4) * 4 + ((im >> (2 * (i % 4))) & 3);
                r = put_el(r, i, ew, get_el(j, k, ew));
            end
        end else if (op == 0) begin
            for (int i = 0; i < 2; i++) begin
                logic [DW-1:0] s = ((im >> (2*i+1)) & 1) ? j : d;
                r = put_el(r, i, 64, get_el(s, (im >> (2*i)) & 1, 64));
            end
        end else if (op == 1) begin
            for (int i = 0; i < 4; i++) begin
                logic [DW-1:0] s = (i < 2) ? j : d;
                r = put_el(r, i, 32, get_el(s, (im >> (2*i)) & 3, 32));
            end
        end else if (op == 2) begin
            r = put_el(d, (im >> 4) & (ne - 1), ew, get_el(j, im & (ne - 1), ew));
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] target_mask(int sz, int im);
        int ew = 8 << sz;
        int ne = DW / ew;
        logic [DW-1:0] ones = '1;
        return put_el('0, (im >> 4) & (ne - 1), ew, ones);
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(int op, int sz, int im);
        logic [DW-1:0] j = {$urandom, $urandom, $urandom, $urandom};
        logic [DW-1:0] d = {$urandom, $urandom, $urandom, $urandom};
        logic [DW-1:0] exp = model(op, sz, im, j, d);
        logic [DW-1:0] m;
        logic [DW-1:0] held;
        string tag;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'(op); esize = 2'(sz); imm = 8'(im);
        src_j = j; src_d = d;
        @(negedge clk);
        in_valid = 1'b0;
        src_j = ~j; src_d = ~d; imm = ~imm;
        check("R7 out_valid", {127'b0, out_valid}, 128'd1);
        if (op == 2) begin
            m = target_mask(sz, im);
            check("R4 inserted element", result & m, exp & m);
            check("R5 untouched elements", result & ~m, exp & ~m);
        end else begin
            tag = (op == 0) ? ((sz < 3) ? "R1 group shuffle" : "R2 dword shuffle")
                : (op == 1) ? "R3 word permute" : "R6 pass old dest";
            check(tag, result, exp);
        end
        held = result;
        @(negedge clk);
        check("R8 hold result", result, held);
        check("R7 valid low", {127'b0, out_valid}, 128'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; op_sel = 2'd0; esize = 2'd0;
        imm = 8'hff; src_j = '1; src_d = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset result", result, '0);
        check("R9 reset valid", {127'b0, out_valid}, 128'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int im = 0; im < 256; im++)
                    run_one(op, sz, im);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule